// File: doc/BRIEF.md
# Spare Stream Status Stripper

This block sits on the byte path that carries a NAND page's spare (out-of-band) area between an ECC engine's buffer and the host. The engine's buffer holds, after each chunk's spare bytes, a group of four status bytes. On a page read the block removes every such group so that the spare bytes leave as one contiguous run: chunk k lands at output offset k*step. While the stream moves, it takes the first byte of each group, which is that chunk's ECC status, and presents it on a sideband together with the chunk index.

The same block serves page writes when the mode bit is set. It then inserts four filler bytes of value 0xFF after every `step` input bytes, which leaves room for the engine's status groups. The per-chunk spare length and the chunk count are loaded with a one-cycle load strobe before the page starts. The chunk count is the page data size divided by the 1 KiB correction step. Both stream sides use valid/ready handshakes. The final output byte of the page carries a last flag. An input last flag that disagrees with the expected length sets an error flag.

Top module: `sss_strip`

## Requirements
- R1: In read mode (`cfg_write` = 0), input byte i with (i mod (step+4)) < step is output in order, and the four group bytes of each chunk are never output. Chunk k's spare bytes appear at output offsets k*step to k*step+step-1.
- R2: In read mode, the byte at input offset step + k*(step+4), the first byte of chunk k's group, is presented on `stat_code` with `stat_chunk` = k. `stat_valid` is high for exactly one cycle, the cycle after that byte is accepted, once per chunk.
- R3: In write mode (`cfg_write` = 1), four bytes of value 0xFF are output after each `step` input bytes. `in_ready` is low while they are output, and the page output length is chunks*(step+4).
- R4: `out_last` is high only together with `out_valid`, and only on the final output byte of the page. In read mode that is the last spare byte of the last chunk. In write mode it is the last filler byte of the last chunk.
- R5: While `out_ready` is low, no output byte is lost or repeated. In read mode the group bytes are still accepted while `out_ready` is low.
- R6: `len_err` is set when `in_last` comes with an accepted byte other than the final input byte of the page. It is also set when the final input byte is accepted without `in_last`. It stays set until the next `cfg_load`, which clears it.
- R7: An input byte accepted with `in_last` before the final position ends the page. The status of a group whose first byte carries that `in_last` is still captured, and `in_ready` stays low afterwards.
- R8: A `cfg_load` with a step of zero or a chunk count of zero leaves the block idle: `in_ready` and `out_valid` stay low.
- R9: In the cycle `cfg_load` is high, no byte moves (`in_ready` and `out_valid` low). A load during a page abandons that page and starts the new one.
- R10: After the final input byte of a page, `in_ready` is low until the next load.
- R11: Out of reset, `in_ready`, `out_valid`, `out_last`, `stat_valid` and `len_err` are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cfg_load | input | 1 | One-cycle strobe that loads the page configuration and starts a page |
| cfg_write | input | 1 | 0: strip groups (read), 1: insert filler (write) |
| cfg_step | input | STEP_W | Spare bytes per chunk |
| cfg_chunks | input | CNT_W | Chunks in the page |
| in_valid | input | 1 | Input byte valid |
| in_ready | output | 1 | Input byte accepted when high with in_valid |
| in_data | input | 8 | Input byte |
| in_last | input | 1 | Sender marks the final input byte of the page |
| out_valid | output | 1 | Output byte valid |
| out_ready | input | 1 | Consumer accepts the output byte |
| out_data | output | 8 | Output byte |
| out_last | output | 1 | Final output byte of the page |
| stat_valid | output | 1 | One-cycle pulse: a chunk status was captured |
| stat_code | output | 8 | Captured status byte |
| stat_chunk | output | CNT_W | Chunk index of the captured status |
| len_err | output | 1 | Sticky length mismatch flag |

## Verification
Status capture and length checking can act on the same accepted byte. This happens when the sender raises `in_last` on the first byte of a status group. The bench provokes it with a read page whose last flag comes at offset `step`. It then expects chunk 0's status on the sideband one cycle later, `len_err` set, exactly `step` output bytes, no `out_last`, and `in_ready` held low afterwards. Load and transfer meeting in one cycle is provoked by raising `cfg_load` while a byte is offered. The bench expects that byte to move only in the following cycle.

// File: rtl/sss_pkg.sv
package sss_pkg;
  typedef enum logic {PH_DATA = 1'b0, PH_GRP = 1'b1} phase_e;

  // byte count on the wide (interleaved) side of one page
  function automatic logic [15:0] wide_len(logic [7:0] step, logic [7:0] chunks,
                                          logic [7:0] grp);
    return 16'(chunks) * (16'(step) + 16'(grp));
  endfunction
endpackage

// File: rtl/sss_tracker.sv
module sss_tracker
  import sss_pkg::*;
#(
  parameter int STEP_W  = 8,
  parameter int CNT_W   = 4,
  parameter int GRP_LEN = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              load,
  input  logic              load_wr,
  input  logic [STEP_W-1:0] load_step,
  input  logic [CNT_W-1:0]  load_chunks,
  input  logic              beat,
  input  logic              abort,
  output logic              active,
  output logic              mode_wr,
  output phase_e            phase,
  output logic [STEP_W-1:0] pos,
  output logic [CNT_W-1:0]  chunk,
  output logic              seg_end,
  output logic              last_chunk
);
  localparam logic [STEP_W-1:0] GRP_LAST = STEP_W'(GRP_LEN - 1);

  logic [STEP_W-1:0] step_q;
  logic [CNT_W-1:0]  nchunk_q;
  logic              load_ok;

  function automatic logic at_seg_end(phase_e ph, logic [STEP_W-1:0] p,
                                      logic [STEP_W-1:0] s);
    return (ph == PH_DATA) ? (p == s - STEP_W'(1)) : (p == GRP_LAST);
  endfunction

  assign load_ok    = (load_step != '0) && (load_chunks != '0);
  assign seg_end    = at_seg_end(phase, pos, step_q);
  assign last_chunk = (chunk == nchunk_q - CNT_W'(1));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      active   <= 1'b0;
      mode_wr  <= 1'b0;
      phase    <= PH_DATA;
      pos      <= '0;
      chunk    <= '0;
      step_q   <= '0;
      nchunk_q <= '0;
    end else if (load) begin
      active   <= load_ok;
      mode_wr  <= load_wr;
      step_q   <= load_step;
      nchunk_q <= load_chunks;
      phase    <= PH_DATA;
      pos      <= '0;
      chunk    <= '0;
    end else if (abort) begin
      active <= 1'b0;
    end else if (beat && active) begin
      if (seg_end) begin
        pos <= '0;
        if (phase == PH_DATA) begin
          phase <= PH_GRP;
        end else begin
          phase <= PH_DATA;
          chunk <= chunk + CNT_W'(1);
          if (last_chunk) active <= 1'b0;
        end
      end else begin
        pos <= pos + STEP_W'(1);
      end
    end
  end
endmodule

// File: rtl/sss_stat_cap.sv
module sss_stat_cap #(
  parameter int CNT_W = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             take,
  input  logic [7:0]       code_in,
  input  logic [CNT_W-1:0] chunk_in,
  output logic             stat_valid,
  output logic [7:0]       stat_code,
  output logic [CNT_W-1:0] stat_chunk
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      stat_valid <= 1'b0;
      stat_code  <= '0;
      stat_chunk <= '0;
    end else begin
      stat_valid <= take;
      if (take) begin
        stat_code  <= code_in;
        stat_chunk <= chunk_in;
      end
    end
  end
endmodule

// File: rtl/sss_len_chk.sv
module sss_len_chk (
  input  logic clk,
  input  logic rst_n,
  input  logic clear,
  input  logic acc,
  input  logic in_last,
  input  logic fin,
  output logic err,
  output logic early
);
  assign early = acc && in_last && !fin;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                     err <= 1'b0;
    else if (clear)                 err <= 1'b0;
    else if (acc && (in_last != fin)) err <= 1'b1;
  end
endmodule

// File: rtl/sss_strip.sv
module sss_strip
  import sss_pkg::*;
#(
  parameter int         STEP_W    = 8,
  parameter int         CNT_W     = 4,
  parameter int         GRP_LEN   = 4,
  parameter logic [7:0] FILL_BYTE = 8'hFF
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cfg_load,
  input  logic              cfg_write,
  input  logic [STEP_W-1:0] cfg_step,
  input  logic [CNT_W-1:0]  cfg_chunks,
  input  logic              in_valid,
  output logic              in_ready,
  input  logic [7:0]        in_data,
  input  logic              in_last,
  output logic              out_valid,
  input  logic              out_ready,
  output logic [7:0]        out_data,
  output logic              out_last,
  output logic              stat_valid,
  output logic [7:0]        stat_code,
  output logic [CNT_W-1:0]  stat_chunk,
  output logic              len_err
);
  // named internal events
  logic              active, mode_wr, seg_end, last_chunk;
  phase_e            phase;
  logic [STEP_W-1:0] pos;
  logic [CNT_W-1:0]  chunk;
  logic              xfer_en, grp_phase, in_acc, out_acc, beat;
  logic              page_end_seg, in_fin, stat_take, early_end;

  assign xfer_en      = active && !cfg_load;
  assign grp_phase    = (phase == PH_GRP);
  assign page_end_seg = seg_end && last_chunk;

  always_comb begin
    if (!mode_wr) begin
      out_valid = xfer_en && !grp_phase && in_valid;
      in_ready  = xfer_en && (grp_phase || out_ready);
      out_data  = in_data;
    end else begin
      out_valid = xfer_en && (grp_phase || in_valid);
      in_ready  = xfer_en && !grp_phase && out_ready;
      out_data  = grp_phase ? FILL_BYTE : in_data;
    end
  end

  assign in_acc    = in_valid && in_ready;
  assign out_acc   = out_valid && out_ready;
  assign beat      = mode_wr ? out_acc : in_acc;
  assign in_fin    = page_end_seg && (mode_wr ? !grp_phase : grp_phase);
  assign out_last  = out_valid && page_end_seg && (mode_wr ? grp_phase : !grp_phase);
  assign stat_take = in_acc && !mode_wr && grp_phase && (pos == '0);

  sss_tracker #(.STEP_W(STEP_W), .CNT_W(CNT_W), .GRP_LEN(GRP_LEN)) u_trk (
    .clk(clk), .rst_n(rst_n), .load(cfg_load), .load_wr(cfg_write),
    .load_step(cfg_step), .load_chunks(cfg_chunks), .beat(beat),
    .abort(early_end), .active(active), .mode_wr(mode_wr), .phase(phase),
    .pos(pos), .chunk(chunk), .seg_end(seg_end), .last_chunk(last_chunk)
  );

  sss_stat_cap #(.CNT_W(CNT_W)) u_cap (
    .clk(clk), .rst_n(rst_n), .take(stat_take), .code_in(in_data),
    .chunk_in(chunk), .stat_valid(stat_valid), .stat_code(stat_code),
    .stat_chunk(stat_chunk)
  );

  sss_len_chk u_len (
    .clk(clk), .rst_n(rst_n), .clear(cfg_load), .acc(in_acc),
    .in_last(in_last), .fin(in_fin), .err(len_err), .early(early_end)
  );
endmodule

// File: rtl/sss_strip_chk.sv
module sss_strip_chk #(
  parameter int         STEP_W    = 8,
  parameter int         CNT_W     = 4,
  parameter logic [7:0] FILL_BYTE = 8'hFF
) (
  input logic              clk,
  input logic              rst_n,
  input logic              cfg_load,
  input logic [STEP_W-1:0] cfg_step,
  input logic [CNT_W-1:0]  cfg_chunks,
  input logic              in_valid,
  input logic              in_ready,
  input logic              out_valid,
  input logic [7:0]        out_data,
  input logic              out_last,
  input logic              stat_valid,
  input logic              len_err,
  input logic              active,
  input logic              mode_wr,
  input logic              grp_phase
);
  // R1
  rd_grp_hidden_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (active && !mode_wr && grp_phase) |-> !out_valid);
  // R3
  fill_value_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && mode_wr && grp_phase) |-> (out_data == FILL_BYTE && !in_ready));
  // R2
  stat_src_chk: assert property (@(posedge clk) disable iff (!rst_n)
    stat_valid |-> $past(in_valid && in_ready && !mode_wr));
  // R2
  stat_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
    stat_valid |=> !stat_valid);
  // R4
  last_valid_chk: assert property (@(posedge clk) disable iff (!rst_n)
    out_last |-> out_valid);
  // R6
  err_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (len_err && !cfg_load) |=> len_err);
  // R9
  load_block_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cfg_load |-> (!in_ready && !out_valid));
  // R8
  bad_cfg_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (cfg_load && (cfg_step == '0 || cfg_chunks == '0)) |=> (!in_ready && !out_valid));
endmodule

bind sss_strip sss_strip_chk #(.STEP_W(STEP_W), .CNT_W(CNT_W), .FILL_BYTE(FILL_BYTE)) u_chk (
  .clk(clk), .rst_n(rst_n), .cfg_load(cfg_load), .cfg_step(cfg_step),
  .cfg_chunks(cfg_chunks), .in_valid(in_valid), .in_ready(in_ready),
  .out_valid(out_valid), .out_data(out_data), .out_last(out_last),
  .stat_valid(stat_valid), .len_err(len_err), .active(active),
  .mode_wr(mode_wr), .grp_phase(grp_phase)
);

// File: tb/sss_strip_test.sv
`timescale 1ns/1ps
module sss_strip_test;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       cfg_load = 1'b0, cfg_write = 1'b0;
  logic [7:0] cfg_step = '0;
  logic [3:0] cfg_chunks = '0;
  logic       in_valid = 1'b0, in_last = 1'b0, out_ready = 1'b1;
  logic [7:0] in_data = '0;
  logic       in_ready, out_valid, out_last, stat_valid, len_err;
  logic [7:0] out_data, stat_code;
  logic [3:0] stat_chunk;

  int total = 0, bad = 0, cyc = 0;
  bit stall_en = 0, done = 0;
  logic [7:0] ob [0:255];
  logic       ol [0:255];
  logic [7:0] sc [0:15];
  logic [3:0] sk [0:15];
  int on = 0, sn = 0;

  always #10 clk = ~clk;

  sss_strip uut (.*);

  // output and sideband monitor, away from the active edge
  always @(negedge clk) begin
    if (out_valid && out_ready && on < 256) begin ob[on] = out_data; ol[on] = out_last; on++; end
    if (stat_valid && sn < 16) begin sc[sn] = stat_code; sk[sn] = stat_chunk; sn++; end
  end

  initial forever begin
    @(posedge clk); #1; cyc++;
    out_ready = stall_en ? ((cyc % 3) != 1) : 1'b1;
  end

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    total++;
    if (!ok) begin bad++; $display("FAIL %s actual=%0d expected=%0d", req, act, exp); end
  endtask

  function automatic logic [7:0] dat(int k, int p); return 8'(k * 32 + p + 1); endfunction
  function automatic logic [7:0] stv(int k);
    return (k == 0) ? 8'h00 : (k == 1) ? 8'hFE : 8'(k * 3);
  endfunction

  task automatic load(bit wr, int step, int n);
    cfg_load = 1; cfg_write = wr; cfg_step = 8'(step); cfg_chunks = 4'(n);
    @(posedge clk); #1; cfg_load = 0;
  endtask

  task automatic send_byte(logic [7:0] d, bit last);
    bit acc;
    in_valid = 1; in_data = d; in_last = last;
    forever begin
      @(negedge clk); acc = in_ready;
      @(posedge clk); #1;
      if (acc) break;
    end
    in_valid = 0; in_last = 0;
  endtask

  task automatic run_page(bit wr, int step, int n, int early_at, bit omit_last, bit stall);
    int tot, lim, en, es, g;
    on = 0; sn = 0; en = 0; es = 0;
    stall_en = stall;
    load(wr, step, n);
    @(negedge clk);
    chk(len_err == 0, "R6 clear on load", len_err, 0);
    @(posedge clk); #1;
    g = step + 4;
    tot = wr ? n * step : n * g;
    lim = (early_at >= 0) ? early_at + 1 : tot;
    for (int i = 0; i < lim; i++) begin
      logic [7:0] d;
      bit lst;
      lst = ((i == tot - 1) && !omit_last) || (i == early_at);
      if (wr) d = dat(i / step, i % step);
      else if ((i % g) < step) d = dat(i / g, i % g);
      else if ((i % g) == step) d = stv(i / g);
      else d = 8'(8'hC0 + (i % g));
      send_byte(d, lst);
    end
    repeat (8) @(posedge clk); #1;
    stall_en = 0;
    // expected output stream
    if (wr) begin
      en = n * g;
      for (int i = 0; i < en && i < on; i++) begin
        logic [7:0] e;
        e = ((i % g) < step) ? dat(i / g, i % g) : 8'hFF;
        chk(ob[i] == e, "R3 write byte", ob[i], e);
        chk(ol[i] == (i == en - 1), "R4 write last", ol[i], (i == en - 1));
      end
    end else begin
      for (int i = 0; i < lim; i++) if ((i % g) < step) en++;
      for (int i = 0; i < lim; i++) if ((i % g) == step) es++;
      for (int i = 0; i < en && i < on; i++) begin
        logic [7:0] e;
        e = dat(i / step, i % step);
        chk(ob[i] == e, stall ? "R5 read byte under stall" : "R1 read byte", ob[i], e);
        chk(ol[i] == (early_at < 0 && i == en - 1), "R4 read last", ol[i], 0);
      end
      chk(sn == es, "R2 status count", sn, es);
      for (int k = 0; k < es && k < sn; k++) begin
        chk(sc[k] == stv(k), "R2 status code", sc[k], stv(k));
        chk(sk[k] == 4'(k), "R2 status chunk", sk[k], k);
      end
    end
    chk(on == en, wr ? "R3 output length" : "R1 output length", on, en);
    @(negedge clk);
    chk(len_err == ((early_at >= 0) || omit_last), "R6 length error", len_err,
        (early_at >= 0) || omit_last);
    chk(in_ready == 0, (early_at >= 0) ? "R7 idle after early last" : "R10 idle after page",
        in_ready, 0);
    @(posedge clk); #1;
  endtask

  task automatic t_reset;
    @(negedge clk);
    chk(!in_ready && !out_valid && !out_last && !stat_valid && !len_err, "R11 reset state",
        {in_ready, out_valid, out_last, stat_valid, len_err}, 0);
  endtask

  task automatic t_load_block;
    cfg_load = 1; cfg_write = 0; cfg_step = 8'd2; cfg_chunks = 4'd1;
    in_valid = 1; in_data = 8'h5A;
    @(negedge clk);
    chk(!in_ready && !out_valid, "R9 no transfer in load cycle", {in_ready, out_valid}, 0);
    @(posedge clk); #1; cfg_load = 0;
    @(negedge clk);
    chk(in_ready && out_valid && out_data == 8'h5A, "R9 transfer after load",
        out_data, 8'h5A);
    @(posedge clk); #1; in_valid = 0;
  endtask

  task automatic t_zero_cfg(int step, int n);
    load(0, step, n);
    in_valid = 1;
    repeat (3) begin
      @(negedge clk);
      chk(!in_ready && !out_valid, "R8 zero config idle", {in_ready, out_valid}, 0);
    end
    @(posedge clk); #1; in_valid = 0;
  endtask

  initial begin
    repeat (2) @(posedge clk);
    t_reset();
    @(posedge clk); #1; rst_n = 1;
    @(posedge clk); #1;
    run_page(0, 6, 3, -1, 0, 0);
    run_page(0, 5, 4, -1, 0, 1);
    run_page(1, 3, 3, -1, 0, 0);
    run_page(1, 4, 2, -1, 0, 1);
    run_page(0, 4, 3, 4, 0, 0);   // R7: last flag on chunk 0 status byte
    run_page(0, 2, 2, -1, 1, 0);  // R6: final byte without last flag
    t_load_block();               // leaves a page half done
    run_page(0, 3, 2, -1, 0, 0);  // R9: restart after abandoned page
    t_zero_cfg(0, 2);
    t_zero_cfg(3, 0);
    done = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      total++; bad++;
      $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule